// File: doc/BRIEF.md
# MDIO Management Frame Engine

This block turns one 32-bit maintenance word, written by software, into a complete clause-22 management frame on the MDC/MDIO pair. The word already carries every field of the frame in its final bit order: the start code, the opcode, the PHY and register addresses, the turnaround code and sixteen data bits. The engine sends a preamble of 32 ones ahead of the word and then shifts the word out most significant bit first, one bit per MDC period.

For a read, the engine stops driving MDIO for the second turnaround bit and the data field. It samples the line on each rising MDC edge and, once the frame ends, puts the sixteen captured bits into the low half of the same maintenance register. Software polls an idle flag before it writes a word and again afterwards. It then reads the word back to get the result.

The MDC half period is a whole number of core clocks chosen by a small divider field. A management-enable input gates the whole engine. While it is low, writes are not accepted, and dropping it during a frame abandons that frame.

Top module: `mdio_frame_engine`

## Requirements
- R1: During reset `idle` is 1, `mdc` is 0, `mdio_oe` is 0 and `maint_rdata` reads 0.
- R2: A `maint_wr` pulse accepted while `idle` is 1 and `mgmt_en` is 1 loads `maint_wdata` into the register and clears `idle` in the next cycle.
- R3: A frame is 32 bits of 1 followed by word bits 31 down to 0, one bit per MDC period. Each bit is set up while MDC is low and holds unchanged while MDC is high.
- R4: Each MDC half period lasts `HALF_UNIT * (div_sel + 1)` clock cycles (16 ns x (div_sel+1) per half at the defaults), and MDC stays low while idle.
- R5: When word bits 29:28 are 2'b10 (read), `mdio_oe` is 0 for word bit 16 and word bits 15:0, which are frame bits 47 to 63, and 1 for all other frame bits. For any other opcode, `mdio_oe` is 1 for all 64 frame bits.
- R6: On a read, MDIO is sampled at each of the sixteen data-bit rising MDC edges. The first sample lands in bit 15. When the frame ends, the samples replace bits 15:0 and bits 31:16 stay as written.
- R7: After a frame whose opcode is not 2'b10, the register still holds the word exactly as written.
- R8: `idle` returns to 1 in the cycle that ends the high half of frame bit 63.
- R9: A `maint_wr` while a frame is in progress changes neither the register nor the frame on the wire.
- R10: A `maint_wr` while `mgmt_en` is 0 starts no frame and leaves the register unchanged.
- R11: When `mgmt_en` falls during a frame, the frame is abandoned. In the next cycle `idle` is 1, `mdc` is 0 and `mdio_oe` is 0, and the register keeps the written word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mgmt_en | input | 1 | Management port enable |
| div_sel | input | DIV_W (3) | MDC divider selection |
| maint_wr | input | 1 | Write strobe for the maintenance word |
| maint_wdata | input | 32 | Maintenance word to load |
| maint_rdata | output | 32 | Maintenance register readback |
| idle | output | 1 | 1 when no management frame is in progress |
| mdc | output | 1 | Management clock |
| mdio_i | input | 1 | MDIO line as seen by the block |
| mdio_o | output | 1 | MDIO value to drive |
| mdio_oe | output | 1 | MDIO output enable |

## Verification
The assertions assume that `div_sel` stays stable while a frame is in progress, because the half-period counter is checked against the limit that field selects. The stimulus changes `div_sel` only while `idle` is 1. The PHY model in the stimulus changes `mdio_i` only on falling MDC edges, so every sample taken at a rising edge sees a settled value. The engine's own assertions cover MDC toggling exactly on divider ticks and the register staying still while busy, and these hold only when the enable and the write strobe are driven between clock edges, which the stimulus does.

// File: rtl/mdio_pkg.sv
`timescale 1ns/1ps
package mdio_pkg;
    localparam int WORD_W   = 32;
    localparam int PRE_BITS = 32;
    localparam int DATA_W   = 16;
    localparam int OP_HI    = 29;
    localparam int OP_LO    = 28;
    localparam logic [1:0] OP_READ = 2'b10;

    typedef enum logic [0:0] {
        ST_IDLE  = 1'b0,
        ST_SHIFT = 1'b1
    } seq_state_e;
endpackage

// File: rtl/mdio_tick_gen.sv
`timescale 1ns/1ps
module mdio_tick_gen #(
    parameter int DIV_W     = 3,
    parameter int HALF_UNIT = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [DIV_W-1:0] div_sel,
    output logic             tick
);
    localparam int CNT_W = $clog2(HALF_UNIT * (1 << DIV_W)) + 1;

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } tick_t;

    tick_t t_q, t_d;
    logic [CNT_W-1:0] limit;

    always_comb begin
        limit = CNT_W'(HALF_UNIT) * (CNT_W'(div_sel) + CNT_W'(1));
        tick  = run && (t_q.cnt >= limit - CNT_W'(1));
        t_d   = t_q;
        if (!run || tick) begin
            t_d.cnt = '0;
        end else begin
            t_d.cnt = t_q.cnt + CNT_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            t_q <= '0;
        end else begin
            t_q <= t_d;
        end
    end

    // R4: the half-period counter never passes the selected limit
    a_r4_cnt_within_limit: assert property (@(posedge clk) disable iff (!rst_n)
        run |-> (t_q.cnt < limit));
endmodule

// File: rtl/mdio_frame_seq.sv
`timescale 1ns/1ps
module mdio_frame_seq #(
    parameter int PRE_N  = 32,
    parameter int WORD_N = 32,
    parameter int DATA_N = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              abort,
    input  logic              tick,
    input  logic              rd_op,
    input  logic [WORD_N-1:0] word,
    output logic              busy,
    output logic              mdc,
    output logic              mdio_o,
    output logic              mdio_oe,
    output logic              sample_stb,
    output logic              done
);
    localparam int FRAME_N = PRE_N + WORD_N;
    localparam int CNT_W   = $clog2(FRAME_N);
    localparam int WB_W    = $clog2(WORD_N);
    localparam logic [CNT_W-1:0] LAST_C = CNT_W'(FRAME_N - 1);
    localparam logic [CNT_W-1:0] PRE_C  = CNT_W'(PRE_N);

    typedef struct packed {
        mdio_pkg::seq_state_e st;
        logic [CNT_W-1:0]     cnt;
        logic                 hi;
    } seq_t;

    seq_t s_q, s_d;
    logic in_word;
    logic [WB_W-1:0] wb;
    logic release_win;
    logic cap_win;

    always_comb begin
        busy        = (s_q.st == mdio_pkg::ST_SHIFT);
        in_word     = (s_q.cnt >= PRE_C);
        wb          = WB_W'(WORD_N - 1) - WB_W'(s_q.cnt - PRE_C);
        release_win = rd_op && in_word && (wb <= WB_W'(DATA_N));
        cap_win     = rd_op && in_word && (wb < WB_W'(DATA_N));

        mdc        = busy && s_q.hi;
        mdio_o     = in_word ? word[wb] : 1'b1;
        mdio_oe    = busy && !release_win;
        sample_stb = busy && tick && !s_q.hi && cap_win && !abort;
        done       = busy && tick && s_q.hi && (s_q.cnt == LAST_C) && !abort;

        s_d = s_q;
        if (busy && abort) begin
            s_d = '{st: mdio_pkg::ST_IDLE, cnt: '0, hi: 1'b0};
        end else if (!busy && start) begin
            s_d = '{st: mdio_pkg::ST_SHIFT, cnt: '0, hi: 1'b0};
        end else if (busy && tick) begin
            if (!s_q.hi) begin
                s_d.hi = 1'b1;
            end else if (s_q.cnt == LAST_C) begin
                s_d = '{st: mdio_pkg::ST_IDLE, cnt: '0, hi: 1'b0};
            end else begin
                s_d.cnt = s_q.cnt + CNT_W'(1);
                s_d.hi  = 1'b0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '{st: mdio_pkg::ST_IDLE, cnt: '0, hi: 1'b0};
        end else begin
            s_q <= s_d;
        end
    end

    // R3: data bit holds while MDC is high
    a_r3_hold_while_high: assert property (@(posedge clk) disable iff (!rst_n)
        (mdc && $past(mdc)) |-> $stable(mdio_o));

    // R4: MDC toggles on every divider tick during a frame
    a_r4_toggle_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && tick && !abort) |=> (mdc != $past(mdc)));

    // R4: MDC holds between divider ticks
    a_r4_hold_between_ticks: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !tick && !abort) |=> $stable(mdc));
endmodule

// File: rtl/mdio_rd_capture.sv
`timescale 1ns/1ps
module mdio_rd_capture #(
    parameter int DATA_N = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              sample_stb,
    input  logic              mdio_i,
    output logic [DATA_N-1:0] rd_data
);
    typedef struct packed {
        logic [DATA_N-1:0] sh;
    } cap_t;

    cap_t c_q, c_d;

    always_comb begin
        c_d = c_q;
        if (clear) begin
            c_d.sh = '0;
        end else if (sample_stb) begin
            c_d.sh = {c_q.sh[DATA_N-2:0], mdio_i};
        end
        rd_data = c_q.sh;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            c_q <= '0;
        end else begin
            c_q <= c_d;
        end
    end

    // R6: a clear and a sample never coincide
    a_r6_no_sample_on_clear: assert property (@(posedge clk) disable iff (!rst_n)
        clear |-> !sample_stb);
endmodule

// File: rtl/mdio_frame_engine.sv
`timescale 1ns/1ps
module mdio_frame_engine #(
    parameter int DIV_W     = 3,
    parameter int HALF_UNIT = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             mgmt_en,
    input  logic [DIV_W-1:0] div_sel,
    input  logic             maint_wr,
    input  logic [31:0]      maint_wdata,
    output logic [31:0]      maint_rdata,
    output logic             idle,
    output logic             mdc,
    input  logic             mdio_i,
    output logic             mdio_o,
    output logic             mdio_oe
);
    localparam int WORD_N = mdio_pkg::WORD_W;
    localparam int DATA_N = mdio_pkg::DATA_W;

    typedef struct packed {
        logic [WORD_N-1:0] maint;
    } eng_t;

    eng_t e_q, e_d;
    logic busy, tick, accept, abort, rd_op, sample_stb, done;
    logic [DATA_N-1:0] rd_data;

    always_comb begin
        accept = maint_wr && !busy && mgmt_en;
        abort  = !mgmt_en;
        rd_op  = (e_q.maint[mdio_pkg::OP_HI:mdio_pkg::OP_LO] == mdio_pkg::OP_READ);
        e_d    = e_q;
        if (accept) begin
            e_d.maint = maint_wdata;
        end else if (done && rd_op) begin
            e_d.maint = {e_q.maint[WORD_N-1:DATA_N], rd_data};
        end
        maint_rdata = e_q.maint;
        idle        = !busy;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            e_q <= '0;
        end else begin
            e_q <= e_d;
        end
    end

    mdio_tick_gen #(
        .DIV_W     (DIV_W),
        .HALF_UNIT (HALF_UNIT)
    ) u_tick (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (busy),
        .div_sel (div_sel),
        .tick    (tick)
    );

    mdio_frame_seq #(
        .PRE_N  (mdio_pkg::PRE_BITS),
        .WORD_N (WORD_N),
        .DATA_N (DATA_N)
    ) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (accept),
        .abort      (abort),
        .tick       (tick),
        .rd_op      (rd_op),
        .word       (e_q.maint),
        .busy       (busy),
        .mdc        (mdc),
        .mdio_o     (mdio_o),
        .mdio_oe    (mdio_oe),
        .sample_stb (sample_stb),
        .done       (done)
    );

    mdio_rd_capture #(
        .DATA_N (DATA_N)
    ) u_cap (
        .clk        (clk),
        .rst_n      (rst_n),
        .clear      (accept),
        .sample_stb (sample_stb),
        .mdio_i     (mdio_i),
        .rd_data    (rd_data)
    );

    // R2: an accepted write starts a frame and shows in the readback
    a_r2_accept_starts: assert property (@(posedge clk) disable iff (!rst_n)
        (idle && maint_wr && mgmt_en) |=> (!idle && maint_rdata == $past(maint_wdata)));

    // R9: register is frozen while a frame runs
    a_r9_busy_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!idle && $past(!idle)) |-> $stable(maint_rdata));

    // R8: the completion strobe leaves the engine idle
    a_r8_done_to_idle: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> idle);

    // R10: with the port disabled the engine stays idle
    a_r10_disabled_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !mgmt_en |=> idle);

    // R11: losing the enable releases the line and stops MDC
    a_r11_abort_release: assert property (@(posedge clk) disable iff (!rst_n)
        (!mgmt_en && !idle) |=> (!mdio_oe && !mdc));
endmodule

// File: tb/mdio_frame_engine_bench.sv
`timescale 1ns/1ps
module mdio_frame_engine_bench;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        mgmt_en;
    logic [2:0]  div_sel;
    logic        maint_wr;
    logic [31:0] maint_wdata;
    logic [31:0] maint_rdata;
    logic        idle, mdc, mdio_i, mdio_o, mdio_oe;

    int n_chk = 0;
    int n_bad = 0;

    always #4 clk = ~clk;

    mdio_frame_engine u_mdio_frame_engine (
        .clk         (clk),
        .rst_n       (rst_n),
        .mgmt_en     (mgmt_en),
        .div_sel     (div_sel),
        .maint_wr    (maint_wr),
        .maint_wdata (maint_wdata),
        .maint_rdata (maint_rdata),
        .idle        (idle),
        .mdc         (mdc),
        .mdio_i      (mdio_i),
        .mdio_o      (mdio_o),
        .mdio_oe     (mdio_oe)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    function automatic logic [31:0] mk(input logic [1:0] op, input logic [4:0] pa,
                                       input logic [4:0] ra, input logic [15:0] d);
        return {2'b01, op, pa, ra, 2'b10, d};
    endfunction

    task automatic wr(input logic [31:0] w);
        @(negedge clk);
        maint_wr    = 1'b1;
        maint_wdata = w;
        @(negedge clk);
        maint_wr    = 1'b0;
    endtask

    task automatic frame(input logic [31:0] w, input int sel,
                         input logic [15:0] phy, input bit poke);
        bit rd;
        int bad_o, bad_oe;
        longint t0, t1;
        logic exp_oe, exp_b;
        rd = (w[29:28] == 2'b10);
        bad_o = 0;
        bad_oe = 0;
        t0 = 0;
        t1 = 0;
        div_sel = 3'(sel);
        mdio_i  = 1'b1;
        wr(w);
        chk(!idle && maint_rdata == w, "R2", "accept and readback", maint_rdata, w);
        for (int k = 0; k < 64; k++) begin
            @(posedge mdc);
            #1;
            if (k == 0) t0 = longint'($time);
            if (k == 1) t1 = longint'($time);
            exp_oe = !(rd && k >= 47);
            exp_b  = (k < 32) ? 1'b1 : w[63-k];
            if (mdio_oe !== exp_oe) bad_oe++;
            if (exp_oe && mdio_o !== exp_b) bad_o++;
            if (poke && k == 10) begin
                @(negedge clk);
                maint_wr    = 1'b1;
                maint_wdata = ~w;
                @(negedge clk);
                maint_wr    = 1'b0;
            end
            @(negedge mdc);
            mdio_i = (k + 1 >= 48 && k + 1 <= 63) ? phy[62-k] : 1'b1;
        end
        #1;
        chk(bad_o == 0, "R3", "frame bit mismatches", 32'(bad_o), 32'd0);
        chk(bad_oe == 0, rd ? "R5" : "R5", "output-enable mismatches", 32'(bad_oe), 32'd0);
        chk((t1 - t0) == longint'(32 * (sel + 1)), "R4", "MDC period ns",
            32'(t1 - t0), 32'(32 * (sel + 1)));
        chk(idle == 1'b1 && mdc == 1'b0, "R8", "idle after frame", {30'd0, idle, mdc}, 32'd2);
        if (rd) chk(maint_rdata == {w[31:16], phy}, "R6", "read result",
                    maint_rdata, {w[31:16], phy});
        else    chk(maint_rdata == w, "R7", "word kept after non-read", maint_rdata, w);
    endtask

    initial begin
        logic [31:0] w, last;
        bit seen;
        rst_n = 1'b0;
        mgmt_en = 1'b1;
        div_sel = '0;
        maint_wr = 1'b0;
        maint_wdata = '0;
        mdio_i = 1'b1;
        repeat (3) @(negedge clk);
        chk(idle == 1'b1, "R1", "reset idle", {31'd0, idle}, 32'd1);
        chk(mdc == 1'b0, "R1", "reset mdc", {31'd0, mdc}, 32'd0);
        chk(mdio_oe == 1'b0, "R1", "reset oe", {31'd0, mdio_oe}, 32'd0);
        chk(maint_rdata == 32'd0, "R1", "reset register", maint_rdata, 32'd0);
        rst_n = 1'b1;

        // read frames across every divider setting
        for (int s = 0; s < 8; s++) begin
            frame(mk(2'b10, 5'(s * 3 + 1), 5'(s + 2), 16'h0000), s,
                  16'hA5C3 ^ 16'(16'h1111 * s), 1'b0);
        end
        // data boundaries
        frame(mk(2'b10, 5'd31, 5'd31, 16'hFFFF), 0, 16'h0000, 1'b0);
        frame(mk(2'b10, 5'd0, 5'd0, 16'h0000), 0, 16'hFFFF, 1'b0);
        frame(mk(2'b10, 5'd5, 5'd1, 16'h0000), 1, 16'h8001, 1'b0);
        // non-read opcodes (R7)
        frame(mk(2'b01, 5'd7, 5'd4, 16'hBEEF), 1, 16'h0000, 1'b0);
        frame(mk(2'b11, 5'd9, 5'd12, 16'h1234), 0, 16'h0000, 1'b0);

        // R9: write during a frame is ignored
        w = mk(2'b10, 5'd3, 5'd6, 16'h0000);
        frame(w, 2, 16'h3C5A, 1'b1);
        chk(maint_rdata[31:16] == w[31:16], "R9", "upper half after busy write",
            {16'd0, maint_rdata[31:16]}, {16'd0, w[31:16]});

        // R10: write while disabled
        last = maint_rdata;
        mgmt_en = 1'b0;
        wr(mk(2'b01, 5'd1, 5'd1, 16'h5555));
        seen = 1'b0;
        for (int i = 0; i < 40; i++) begin
            @(negedge clk);
            if (mdc || !idle) seen = 1'b1;
        end
        chk(!seen, "R10", "activity while disabled", {31'd0, seen}, 32'd0);
        chk(maint_rdata == last, "R10", "register while disabled", maint_rdata, last);
        mgmt_en = 1'b1;

        // R11: abort by dropping the enable
        div_sel = 3'd0;
        w = mk(2'b10, 5'd2, 5'd2, 16'h0000);
        wr(w);
        repeat (5) @(posedge mdc);
        @(negedge clk);
        mgmt_en = 1'b0;
        @(negedge clk);
        chk(idle && !mdc && !mdio_oe, "R11", "idle/mdc/oe after abort",
            {29'd0, idle, mdc, mdio_oe}, 32'd4);
        chk(maint_rdata == w, "R11", "register after abort", maint_rdata, w);
        mgmt_en = 1'b1;
        frame(mk(2'b10, 5'd4, 5'd8, 16'h0000), 0, 16'h6A95, 1'b0);

        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL R8 watchdog: actual busy expected idle");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule